// File: doc/BRIEF.md
# Ping-Pong Sample Capture Controller

This block moves a continuous stream of converter samples out of an input FIFO and into two external memory banks, taking turns between them. While one bank is being filled, a host processor drains the other, which it filled earlier. The block drives a shared write address, one write enable per bank, and the write data. When the active bank holds its last word, the block raises a level interrupt and reports which bank is ready. In that same cycle it turns the write path to the other bank, so storage never stops.

The host clears the interrupt with a one-cycle acknowledge pulse once it has read the bank. If a bank fills while the previous interrupt is still pending, a sticky overrun flag is set. Writing carries on regardless, and the unread bank gets overwritten. Samples are 12 bits wide by default and may arrive on every clock.

Top module: `pingpong_capture`

## Requirements
- R1: After reset, irq and overrun are low, neither write enable is active, and the first sample after reset is written to bank 0 (the first bank) at address 0.
- R2: fifo_rd is high in exactly those cycles, out of reset, in which fifo_empty is low.
- R3: Every cycle with fifo_rd high is followed, in the next cycle, by exactly one bank write. The write carries the fifo_data value present in that cycle. No write occurs without a read strobe in the previous cycle.
- R4: Within a bank, writes go to addresses 0, 1, … DEPTH-1. After DEPTH writes the next write goes to the other bank at address 0. Banks alternate 0, 1, 0, … and an uninterrupted input stream is written with no idle cycle at the swap.
- R5: irq rises in the cycle after the write to address DEPTH-1. ready_bank then shows the bank that just filled (0 = first bank, 1 = second bank).
- R6: irq stays high until an irq_ack pulse and is low in the cycle after the acknowledge. An acknowledge while irq is low has no effect.
- R7: If a bank fills while irq is high and irq_ack is low, overrun goes high and stays high until reset. Writing continues into the unread bank, and ready_bank moves to the newest full bank.
- R8: If irq_ack arrives in the same cycle as the write that fills a bank, irq stays high, ready_bank shows the new bank, and overrun is not set.
- R9: mem_we0 and mem_we1 are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_empty | input | 1 | Input FIFO has no data |
| fifo_rd | output | 1 | Read strobe to the input FIFO |
| fifo_data | input | DATA_W | FIFO output word, valid the cycle after fifo_rd |
| mem_addr | output | ADDR_W | Shared write address of both banks |
| mem_wdata | output | DATA_W | Write data to both banks |
| mem_we0 | output | 1 | Write enable of bank 0 |
| mem_we1 | output | 1 | Write enable of bank 1 |
| irq | output | 1 | Level interrupt: a bank is full and unread |
| irq_ack | input | 1 | Host acknowledge pulse |
| ready_bank | output | 1 | Index of the bank that is full |
| overrun | output | 1 | Sticky flag: a bank filled before the previous one was acknowledged |

## Verification
The following are checked on every cycle by the assertions:
- the strobe gating;
- the one-cycle read-to-write latency;
- exclusive bank enables;
- interrupt hold and clear on acknowledge;
- the cause of each interrupt rise and the bank it reports;
- the setting and stickiness of overrun.

Other behaviour can only be shown by the bench's scenarios, which track every sample from FIFO to bank:
- the address and bank sequence across many swaps;
- the memory contents the host would read;
- absence of a gap at the swap under a steady stream;
- the collision of an acknowledge with a full event;
- a reset in the middle of a run.

// File: rtl/pp_pkg.sv
package pp_pkg;

    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_e;

    typedef struct packed {
        logic  pending;
        bank_e ready;
        logic  overrun;
    } irq_st_t;

    typedef struct packed {
        logic wr_valid;
    } issue_st_t;

endpackage

// File: rtl/pp_addr_gen.sv
module pp_addr_gen #(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              wrap
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } addr_st_t;

    addr_st_t s_d, s_q;

    // Wrap is flagged on the write that lands on the last word.
    always_comb begin
        s_d  = s_q;
        wrap = step && (s_q.addr == LAST);
        if (step) begin
            s_d.addr = wrap ? '0 : s_q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign addr = s_q.addr;
endmodule

// File: rtl/pp_bank_sel.sv
module pp_bank_sel
    import pp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wrap,
    output bank_e bank
);
    typedef struct packed {
        bank_e bank;
    } bank_st_t;

    bank_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wrap) begin
            s_d.bank = (s_q.bank == BANK_A) ? BANK_B : BANK_A;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{bank: BANK_A};
        else        s_q <= s_d;
    end

    assign bank = s_q.bank;
endmodule

// File: rtl/pp_irq_ctrl.sv
module pp_irq_ctrl
    import pp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  full,
    input  bank_e full_bank,
    input  logic  ack,
    output logic  irq,
    output bank_e ready_bank,
    output logic  overrun
);
    irq_st_t s_d, s_q;

    // A full event outranks an acknowledge in the same cycle.
    always_comb begin
        s_d = s_q;
        if (ack) begin
            s_d.pending = 1'b0;
        end
        if (full) begin
            if (s_q.pending && !ack) begin
                s_d.overrun = 1'b1;
            end
            s_d.pending = 1'b1;
            s_d.ready   = full_bank;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{pending: 1'b0, ready: BANK_A, overrun: 1'b0};
        else        s_q <= s_d;
    end

    assign irq        = s_q.pending;
    assign ready_bank = s_q.ready;
    assign overrun    = s_q.overrun;
endmodule

// File: rtl/pingpong_capture.sv
module pingpong_capture
    import pp_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 512,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_empty,
    output logic              fifo_rd,
    input  logic [DATA_W-1:0] fifo_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we0,
    output logic              mem_we1,
    output logic              irq,
    input  logic              irq_ack,
    output logic              ready_bank,
    output logic              overrun
);
    issue_st_t s_d, s_q;
    logic      wr_now;
    logic      wrap;
    bank_e     bank;
    bank_e     rdy;

    // Strobe the FIFO whenever it has data; the word is stored one cycle later.
    always_comb begin
        s_d          = s_q;
        fifo_rd      = rst_n && !fifo_empty;
        s_d.wr_valid = fifo_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_now = s_q.wr_valid;

    pp_addr_gen #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (wr_now),
        .addr  (mem_addr),
        .wrap  (wrap)
    );

    pp_bank_sel u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wrap  (wrap),
        .bank  (bank)
    );

    pp_irq_ctrl u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .full       (wrap),
        .full_bank  (bank),
        .ack        (irq_ack),
        .irq        (irq),
        .ready_bank (rdy),
        .overrun    (overrun)
    );

    assign mem_wdata  = fifo_data;
    assign mem_we0    = wr_now && (bank == BANK_A);
    assign mem_we1    = wr_now && (bank == BANK_B);
    assign ready_bank = rdy;
endmodule

// File: rtl/pp_capture_chk.sv
module pp_capture_chk #(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_empty,
    input logic              fifo_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we0,
    input logic              mem_we1,
    input logic              irq,
    input logic              irq_ack,
    input logic              ready_bank,
    input logic              overrun
);
    logic any_we;
    logic full_wr;
    assign any_we  = mem_we0 || mem_we1;
    assign full_wr = any_we && (mem_addr == ADDR_W'(DEPTH - 1));

    AST_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n) fifo_rd |-> !fifo_empty); // R2
    AST_RD_WHEN_AVAIL: assert property (@(posedge clk) disable iff (!rst_n) !fifo_empty |-> fifo_rd); // R2
    AST_WE_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n) fifo_rd |=> any_we); // R3
    AST_NO_STRAY_WE: assert property (@(posedge clk) disable iff (!rst_n) any_we |-> $past(fifo_rd)); // R3
    AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({mem_we0, mem_we1})); // R9
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> $past(full_wr)); // R5
    AST_IRQ_BANK: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> ready_bank == $past(mem_we1)); // R5
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (irq && !irq_ack) |=> irq); // R6
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (irq_ack && !full_wr) |=> !irq); // R6
    AST_ACK_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n) (irq_ack && full_wr && !overrun) |=> (irq && !overrun)); // R8
    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n) (full_wr && irq && !irq_ack) |=> overrun); // R7
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overrun |=> overrun); // R7
endmodule

bind pingpong_capture pp_capture_chk #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_empty (fifo_empty),
    .fifo_rd    (fifo_rd),
    .mem_addr   (mem_addr),
    .mem_we0    (mem_we0),
    .mem_we1    (mem_we1),
    .irq        (irq),
    .irq_ack    (irq_ack),
    .ready_bank (ready_bank),
    .overrun    (overrun)
);

// File: tb/pingpong_capture_tb.sv
module pingpong_capture_tb;
    localparam int DATA_W = 12;
    localparam int DEPTH  = 8;
    localparam int ADDR_W = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fifo_empty = 1'b1;
    logic              fifo_rd;
    logic [DATA_W-1:0] fifo_data = '0;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_we0, mem_we1;
    logic              irq;
    logic              irq_ack = 1'b0;
    logic              ready_bank;
    logic              overrun;

    int checks = 0, fails = 0;
    int mon_checks = 0, mon_fails = 0;
    int sent = 0;
    bit done = 1'b0;

    logic [DATA_W-1:0] mem_a [DEPTH];
    logic [DATA_W-1:0] mem_b [DEPTH];

    always #4 clk = ~clk;

    pingpong_capture #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .fifo_rd    (fifo_rd),
        .fifo_data  (fifo_data),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_we0    (mem_we0),
        .mem_we1    (mem_we1),
        .irq        (irq),
        .irq_ack    (irq_ack),
        .ready_bank (ready_bank),
        .overrun    (overrun)
    );

    function automatic logic [DATA_W-1:0] val(int k);
        return DATA_W'((k * 291 + 17) & ((1 << DATA_W) - 1));
    endfunction

    // FIFO model: word appears the cycle after the read strobe
    always @(posedge clk) begin
        if (!rst_n) sent <= 0;
        else if (fifo_rd) begin
            fifo_data <= val(sent);
            sent      <= sent + 1;
        end
    end

    // Bank models
    always @(posedge clk) begin
        if (mem_we0) mem_a[mem_addr] <= mem_wdata;
        if (mem_we1) mem_b[mem_addr] <= mem_wdata;
    end

    // Per-cycle write monitor
    int wr_idx = 0;
    bit rd_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            wr_idx  = 0;
            rd_prev = 1'b0;
        end else begin
            mon_checks++;
            if (fifo_rd != !fifo_empty) begin
                mon_fails++;
                $display("FAIL R2 fifo_rd act=%0d exp=%0d", fifo_rd, !fifo_empty);
            end
            mon_checks++;
            if ((mem_we0 || mem_we1) != rd_prev) begin
                mon_fails++;
                $display("FAIL R3 write act=%0d exp=%0d", mem_we0 || mem_we1, rd_prev);
            end
            mon_checks++;
            if (mem_we0 && mem_we1) begin
                mon_fails++;
                $display("FAIL R9 enables act=11 exp=one-hot");
            end
            if (mem_we0 || mem_we1) begin
                mon_checks++;
                if (mem_we1 != ((wr_idx / DEPTH) % 2 == 1) || int'(mem_addr) != wr_idx % DEPTH) begin
                    mon_fails++;
                    $display("FAIL R4 write %0d bank/addr act=%0d/%0d exp=%0d/%0d", wr_idx,
                             mem_we1, mem_addr, (wr_idx / DEPTH) % 2, wr_idx % DEPTH);
                end
                mon_checks++;
                if (mem_wdata != val(wr_idx)) begin
                    mon_fails++;
                    $display("FAIL R3 data act=%0h exp=%0h", mem_wdata, val(wr_idx));
                end
                wr_idx++;
            end
            rd_prev = fifo_rd;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic feed(int n);
        fifo_empty = 1'b0;
        repeat (n) step();
        fifo_empty = 1'b1;
    endtask

    task automatic feed_gappy(int n);
        int got = 0;
        for (int c = 0; got < n; c++) begin
            bit e = ((c * 5) % 7) < 2;
            fifo_empty = e;
            step();
            if (!e) got++;
        end
        fifo_empty = 1'b1;
    endtask

    task automatic ack_pulse();
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
    endtask

    task automatic check_bank(bit b, int fill, string req);
        for (int i = 0; i < DEPTH; i++) begin
            chk(req, b ? int'(mem_b[i]) : int'(mem_a[i]), int'(val(fill * DEPTH + i)));
        end
    endtask

    initial begin
        #(8 * 50000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     checks + mon_checks + 1, fails + mon_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        // R1: reset state
        chk("R1 irq", irq, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 we", mem_we0 | mem_we1, 0);
        rst_n = 1'b1;
        step();
        chk("R2 idle strobe", fifo_rd, 0);

        // Fill 0 into bank 0
        feed(DEPTH);
        chk("R5 irq not early", irq, 0);
        step();
        chk("R5 irq", irq, 1);
        chk("R1 first bank", ready_bank, 0);
        check_bank(1'b0, 0, "R4 bank0 fill0");
        ack_pulse();
        chk("R6 ack clears", irq, 0);
        ack_pulse();
        chk("R6 stray ack irq", irq, 0);
        chk("R6 stray ack overrun", overrun, 0);

        // Fill 1 into bank 1
        feed(DEPTH);
        step();
        chk("R5 irq fill1", irq, 1);
        chk("R5 ready fill1", ready_bank, 1);
        check_bank(1'b1, 1, "R4 bank1 fill1");
        step();
        chk("R6 irq held", irq, 1);
        ack_pulse();

        // Fill 2 with gaps into bank 0
        feed_gappy(DEPTH);
        step();
        chk("R5 irq gappy", irq, 1);
        chk("R5 ready gappy", ready_bank, 0);
        check_bank(1'b0, 2, "R3 gappy fill2");
        ack_pulse();

        // Fills 3 and 4 back to back, acked in between
        fork
            feed(2 * DEPTH);
            begin
                repeat (DEPTH + 3) step();
                ack_pulse();
            end
        join
        step();
        chk("R4 steady irq", irq, 1);
        chk("R4 steady ready", ready_bank, 0);
        chk("R4 steady overrun", overrun, 0);
        check_bank(1'b1, 3, "R4 steady fill3");
        check_bank(1'b0, 4, "R4 steady fill4");
        ack_pulse();

        // Acknowledge colliding with a full event
        feed(DEPTH);
        step();
        chk("R5 ready fill5", ready_bank, 1);
        feed(DEPTH - 1);
        fifo_empty = 1'b0;
        step();
        fifo_empty = 1'b1;
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
        chk("R8 irq stays", irq, 1);
        chk("R8 ready new", ready_bank, 0);
        chk("R8 no overrun", overrun, 0);
        check_bank(1'b0, 6, "R8 fill6");
        ack_pulse();
        chk("R6 irq cleared", irq, 0);

        // Overrun
        feed(DEPTH);
        step();
        chk("R7 pre overrun", overrun, 0);
        feed(DEPTH);
        step();
        chk("R7 overrun", overrun, 1);
        chk("R7 irq", irq, 1);
        chk("R7 ready newest", ready_bank, 0);
        check_bank(1'b0, 8, "R7 overwrite");
        ack_pulse();
        chk("R7 irq acked", irq, 0);
        chk("R7 sticky after ack", overrun, 1);
        feed(3);
        repeat (2) step();
        chk("R7 sticky later", overrun, 1);

        // Reset mid-run
        rst_n = 1'b0;
        repeat (2) step();
        chk("R1 reset irq", irq, 0);
        chk("R1 reset overrun", overrun, 0);
        rst_n = 1'b1;
        step();
        feed(DEPTH);
        step();
        chk("R1 restart irq", irq, 1);
        chk("R1 restart bank", ready_bank, 0);
        check_bank(1'b0, 0, "R1 restart fill");
        repeat (3) step();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 checks + mon_checks, fails + mon_fails);
        $finish;
    end
endmodule